// File: doc/BRIEF.md
# Indirect Buffer Access Port

This block lets a host reach a local buffer RAM through three I/O ports instead of a memory-mapped window. The host sets a buffer pointer by writing its two halves, one after the other, to an address port. After that, reads and writes on the low data port move bytes or 16-bit words between the host and the RAM at the pointer, and the pointer advances after each transfer. The bytes come from the RAM directly, so the host never needs an address window in its memory space. While the pipe is enabled, the block tells the memory-space decoders to stay off.

Reads are served from a prefetch register that the block refills after every pointer change. The host sees the data at the pointer on its next read strobe, with no extra wait. The block keeps track of the transfer direction. Once a read has happened, writes are refused until the host loads the address again.

Top module: `hostpipe_bridge`

## Requirements
- R1: During reset and after it, `buf_ptr`, `host_rdata`, `wr_ok`, `ram_we` and `ram_re` are 0, and `mem_dec_en` is 1.
- R2: A `host_wr` to port 0 (address) stores `host_wdata[7:0]` as the pending low half. A second consecutive port-0 write sets `buf_ptr` to {second[7:0], first[7:0]} in the cycle after its strobe. That second write also sets `wr_ok` to 1.
- R3: Any `host_rd` or `host_wr` strobe that is not a port-0 write abandons a pending low half, and `buf_ptr` stays unchanged. The next port-0 write then counts as a new first write.
- R4: If `odd_start` is 1 on the completing address write, bit 0 of the loaded pointer is forced to 1.
- R5: Before any address load, port-1 reads and port-1 writes are refused. After an accepted read, port-1 writes are refused (no `ram_we`, pointer unchanged) and `wr_ok` is 0 until the next completed address load.
- R6: An accepted write on port 1 (low data) produces a one-cycle `ram_we` in the next cycle. During that cycle `ram_addr` is the pre-transfer pointer, `ram_wdata` holds the host data and `ram_wide` equals `host_wide`. The pointer then advances by 2 when `host_wide` is 1 and by 1 otherwise.
- R7: Strobes on port 2 (high data) and port 3 (another device register) transfer nothing and leave the pointer unchanged. All byte transfers go through port 1.
- R8: An accepted read on port 1 updates `host_rdata` in the cycle after the strobe. For a wide read it holds {RAM[ptr+1], RAM[ptr]}; for a byte read it holds {8'h00, RAM[ptr]}. The pointer advances as in R6. Strobes must be at least 5 cycles apart. The RAM answers `ram_re` on `ram_rdata` one cycle later, with RAM[addr] in bits [7:0] and RAM[addr+1] in bits [15:8].
- R9: The pipe is active only while `pipe_en` is 1 and `mem_win_en` is 0. While it is inactive, address and data strobes have no effect. `mem_dec_en` shows the inverse of activity one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_en | input | 1 | Pipe enable control bit |
| mem_win_en | input | 1 | Memory window enable control bit |
| odd_start | input | 1 | Force pointer bit 0 on address load |
| host_sel | input | 2 | Port select: 0 address, 1 low data, 2 high data, 3 other |
| host_rd | input | 1 | One-cycle host read strobe |
| host_wr | input | 1 | One-cycle host write strobe |
| host_wide | input | 1 | 16-bit transfer when 1 |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| buf_ptr | output | 16 | Buffer pointer |
| wr_ok | output | 1 | Address valid for writing |
| mem_dec_en | output | 1 | Memory-space decoder enable |
| ram_addr | output | 16 | RAM byte address |
| ram_re | output | 1 | RAM read request |
| ram_we | output | 1 | RAM write strobe |
| ram_wide | output | 1 | RAM write covers two bytes |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, two bytes |

## Verification
The hardest case to reach is an address sequence broken between its two writes by an unrelated device access. It has to be told apart from the legal ways of changing the pointer. The stimulus writes a first half, then strobes port 3, then shows that the next address write counts as a first half: the pointer holds its old value until a further write completes a new load. A read followed by an attempted write, then a reload to the same address, covers the direction lock.

// File: rtl/hostpipe_pkg.sv
package hostpipe_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_LO    = 2'd1,
    SEL_HI    = 2'd2,
    SEL_OTHER = 2'd3
  } port_e;
endpackage

// File: rtl/hostpipe_addr.sv
module hostpipe_addr #(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_wr,
  input  logic            cancel,
  input  logic            odd_start,
  input  logic            adv,
  input  logic [1:0]      step,
  input  logic [AW/2-1:0] half_in,
  output logic [AW-1:0]   ptr,
  output logic            load_now
);
  localparam int HALF = AW / 2;

  logic            pend;
  logic [HALF-1:0] hold;

  assign load_now = addr_wr & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      hold <= '0;
      ptr  <= '0;
    end else if (addr_wr) begin
      if (pend) begin
        ptr  <= {half_in, hold[HALF-1:1], hold[0] | odd_start};
        pend <= 1'b0;
      end else begin
        hold <= half_in;
        pend <= 1'b1;
      end
    end else begin
      if (cancel) pend <= 1'b0;
      if (adv)    ptr  <= ptr + AW'(step);
    end
  end

  p_abandon_keeps_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    (cancel && !addr_wr && !adv) |=> $stable(ptr));
  p_upper_half_r2: assert property (@(posedge clk) disable iff (rst)
    load_now |=> ptr[AW-1:HALF] == $past(half_in));
  p_odd_force_r4: assert property (@(posedge clk) disable iff (rst)
    (load_now && odd_start) |=> ptr[0]);
endmodule

// File: rtl/hostpipe_dir.sv
module hostpipe_dir (
  input  logic clk,
  input  logic rst,
  input  logic load_now,
  input  logic rd_take,
  output logic wr_ok,
  output logic rd_ok
);
  logic loaded, rd_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded  <= 1'b0;
      rd_seen <= 1'b0;
    end else if (load_now) begin
      loaded  <= 1'b1;
      rd_seen <= 1'b0;
    end else if (rd_take) begin
      rd_seen <= 1'b1;
    end
  end

  assign wr_ok = loaded & ~rd_seen;
  assign rd_ok = loaded;

  p_read_locks_writes_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_take && !load_now) |=> !wr_ok);
  p_reload_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
    load_now |=> wr_ok);
endmodule

// File: rtl/hostpipe_pf.sv
module hostpipe_pf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [DW-1:0] ram_rdata,
  output logic          issue,
  output logic [DW-1:0] pf
);
  logic s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      pf    <= '0;
    end else begin
      issue <= req;
      s2    <= issue;
      s3    <= s2;
      if (s3) pf <= ram_rdata;
    end
  end
endmodule

// File: rtl/hostpipe_bridge.sv
module hostpipe_bridge #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_en,
  input  logic          mem_win_en,
  input  logic          odd_start,
  input  logic [1:0]    host_sel,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_wide,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] buf_ptr,
  output logic          wr_ok,
  output logic          mem_dec_en,
  output logic [AW-1:0] ram_addr,
  output logic          ram_re,
  output logic          ram_we,
  output logic          ram_wide,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  import hostpipe_pkg::*;
  localparam int HALF = AW / 2;
  localparam int LANE = DW / 2;

  logic          active, addr_wr, cancel, lo_sel;
  logic          rd_ok, rd_take, wr_take, adv, load_now, issue;
  logic [1:0]    step;
  logic [DW-1:0] pf;

  assign active  = pipe_en & ~mem_win_en;
  assign lo_sel  = (port_e'(host_sel) == SEL_LO);
  assign addr_wr = host_wr & active & (port_e'(host_sel) == SEL_ADDR);
  assign cancel  = (host_rd | host_wr) & ~addr_wr;
  assign rd_take = host_rd & active & lo_sel & rd_ok;
  assign wr_take = host_wr & active & lo_sel & wr_ok;
  assign adv     = rd_take | wr_take;
  assign step    = host_wide ? 2'd2 : 2'd1;

  hostpipe_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .cancel(cancel),
    .odd_start(odd_start), .adv(adv), .step(step),
    .half_in(host_wdata[HALF-1:0]), .ptr(buf_ptr), .load_now(load_now)
  );

  hostpipe_dir u_dir (
    .clk(clk), .rst(rst), .load_now(load_now), .rd_take(rd_take),
    .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  hostpipe_pf #(.DW(DW)) u_pf (
    .clk(clk), .rst(rst), .req(load_now | adv), .ram_rdata(ram_rdata),
    .issue(issue), .pf(pf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      mem_dec_en <= 1'b1;
      ram_addr   <= '0;
      ram_re     <= 1'b0;
      ram_we     <= 1'b0;
      ram_wide   <= 1'b0;
      ram_wdata  <= '0;
    end else begin
      mem_dec_en <= ~active;
      ram_addr   <= buf_ptr;
      ram_re     <= issue;
      ram_we     <= wr_take;
      if (wr_take) begin
        ram_wdata <= host_wdata;
        ram_wide  <= host_wide;
      end
      if (rd_take)
        host_rdata <= host_wide ? pf : {{LANE{1'b0}}, pf[LANE-1:0]};
    end
  end

  p_write_needs_ok_r5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(wr_ok));
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ram_we);
  p_high_port_inert_r7: assert property (@(posedge clk) disable iff (rst)
    (port_e'(host_sel) != SEL_LO) |=> !ram_we);
endmodule

// File: tb/hostpipe_bridge_test.sv
module hostpipe_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic pipe_en = 1'b0, mem_win_en = 1'b0, odd_start = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic host_rd = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata, buf_ptr, ram_addr, ram_wdata;
  logic [15:0] ram_rdata = '0;
  logic wr_ok, mem_dec_en, ram_re, ram_we, ram_wide;

  int checks = 0, errors = 0, we_cnt = 0, last_wa = 0, last_wide = 0;
  bit started = 0, done = 0;
  logic [7:0] mem [256];
  logic [7:0] mref [256];
  int m_ptr = 0, m_pend = 0, m_hold = 0, m_loaded = 0, m_rd = 0, m_rdata = 0, m_dec = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostpipe_bridge uut (
    .clk(clk), .rst(rst), .pipe_en(pipe_en), .mem_win_en(mem_win_en),
    .odd_start(odd_start), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .host_wide(host_wide), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .buf_ptr(buf_ptr), .wr_ok(wr_ok),
    .mem_dec_en(mem_dec_en), .ram_addr(ram_addr), .ram_re(ram_re),
    .ram_we(ram_we), .ram_wide(ram_wide), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'((i * 7 + 3) & 255);
      mref[i] = 8'((i * 7 + 3) & 255);
    end
  end

  // RAM model
  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr[7:0]] <= ram_wdata[7:0];
      if (ram_wide) mem[8'(ram_addr[7:0] + 8'd1)] <= ram_wdata[15:8];
      we_cnt++;
      last_wa = ram_addr;
      last_wide = ram_wide;
    end
    if (ram_re) ram_rdata <= {mem[8'(ram_addr[7:0] + 8'd1)], mem[ram_addr[7:0]]};
  end

  // Behavioural reference model
  always @(posedge clk) begin
    int p, n;
    started = 1;
    p = m_ptr & 255;
    n = host_wide ? 2 : 1;
    if (rst) begin
      m_ptr = 0; m_pend = 0; m_hold = 0; m_loaded = 0; m_rd = 0; m_rdata = 0; m_dec = 1;
    end else begin
      m_dec = (pipe_en && !mem_win_en) ? 0 : 1;
      if (host_wr && m_dec == 0 && host_sel == 2'd0) begin
        if (m_pend != 0) begin
          m_ptr = ((host_wdata & 255) << 8) | m_hold | (odd_start ? 1 : 0);
          m_pend = 0; m_loaded = 1; m_rd = 0;
        end else begin
          m_hold = host_wdata & 255; m_pend = 1;
        end
      end else begin
        if (host_rd || host_wr) m_pend = 0;
        if (m_dec == 0 && host_sel == 2'd1 && m_loaded != 0) begin
          if (host_rd) begin
            m_rdata = host_wide ? ((int'(mref[(p + 1) & 255]) << 8) | mref[p]) : int'(mref[p]);
            m_ptr = (m_ptr + n) & 16'hFFFF; m_rd = 1;
          end else if (host_wr && m_rd == 0) begin
            mref[p] = host_wdata[7:0];
            if (host_wide) mref[(p + 1) & 255] = host_wdata[15:8];
            m_ptr = (m_ptr + n) & 16'hFFFF;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 R3 R6 model buf_ptr", int'(buf_ptr), m_ptr);
      chk("R5 model wr_ok", int'(wr_ok), (m_loaded != 0 && m_rd == 0) ? 1 : 0);
      chk("R8 model host_rdata", int'(host_rdata), m_rdata);
      chk("R9 model mem_dec_en", int'(mem_dec_en), m_dec);
    end
  end

  task automatic strobe(bit rd, bit wr, logic [1:0] sel, bit wide, logic [15:0] d);
    host_sel = sel; host_wide = wide; host_wdata = d; host_rd = rd; host_wr = wr;
    @(negedge clk);
    host_rd = 0; host_wr = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic load(logic [7:0] lo, logic [7:0] hi);
    strobe(0, 1, 2'd0, 0, {8'h00, lo});
    strobe(0, 1, 2'd0, 0, {8'h00, hi});
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk("R1 buf_ptr in reset", int'(buf_ptr), 0);
    chk("R1 wr_ok in reset", int'(wr_ok), 0);
    chk("R1 mem_dec_en in reset", int'(mem_dec_en), 1);
    chk("R1 ram strobes in reset", int'({ram_we, ram_re}), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 host_rdata after reset", int'(host_rdata), 0);
    pipe_en = 1;
    repeat (2) @(negedge clk);
    chk("R9 decoders off while active", int'(mem_dec_en), 0);

    // R5: no load yet
    w = we_cnt;
    strobe(0, 1, 2'd1, 1, 16'h1111);
    chk("R5 write before load refused", we_cnt, w);
    chk("R5 pointer kept before load", int'(buf_ptr), 0);

    // R2 load
    load(8'h10, 8'h12);
    chk("R2 pointer loaded", int'(buf_ptr), 16'h1210);
    chk("R2 wr_ok after load", int'(wr_ok), 1);

    // R6 writes
    strobe(0, 1, 2'd1, 1, 16'hBEEF);
    chk("R6 word write count", we_cnt, w + 1);
    chk("R6 word write addr", last_wa, 16'h1210);
    chk("R6 word write wide", last_wide, 1);
    chk("R6 pointer +2", int'(buf_ptr), 16'h1212);
    strobe(0, 1, 2'd1, 0, 16'h0055);
    chk("R6 byte write wide", last_wide, 0);
    chk("R6 pointer +1", int'(buf_ptr), 16'h1213);

    // R7 high port and other register
    w = we_cnt;
    strobe(0, 1, 2'd2, 0, 16'h00AA);
    strobe(1, 0, 2'd3, 0, 16'h0000);
    chk("R7 high port no write", we_cnt, w);
    chk("R7 pointer unchanged", int'(buf_ptr), 16'h1213);

    // R8 reads
    load(8'h10, 8'h12);
    strobe(1, 0, 2'd1, 1, 16'h0000);
    chk("R8 word read data", int'(host_rdata), 16'hBEEF);
    chk("R8 pointer +2", int'(buf_ptr), 16'h1212);
    strobe(1, 0, 2'd1, 0, 16'h0000);
    chk("R8 byte read data", int'(host_rdata), 16'h0055);

    // R5 direction lock
    w = we_cnt;
    strobe(0, 1, 2'd1, 0, 16'h0077);
    chk("R5 write after read refused", we_cnt, w);
    chk("R5 wr_ok low after read", int'(wr_ok), 0);
    chk("R5 pointer unchanged", int'(buf_ptr), 16'h1213);
    load(8'h13, 8'h12);
    chk("R5 reload same address unlocks", int'(wr_ok), 1);

    // R3 interrupted sequence
    strobe(0, 1, 2'd0, 0, 16'h0040);
    strobe(1, 0, 2'd3, 0, 16'h0000);
    strobe(0, 1, 2'd0, 0, 16'h0050);
    chk("R3 interrupted load leaves pointer", int'(buf_ptr), 16'h1213);
    strobe(0, 1, 2'd0, 0, 16'h0020);
    chk("R3 fresh sequence loads", int'(buf_ptr), 16'h2050);

    // R4 odd start
    odd_start = 1;
    load(8'h00, 8'h30);
    odd_start = 0;
    chk("R4 bit0 forced", int'(buf_ptr), 16'h3001);
    strobe(0, 1, 2'd1, 1, 16'hA55A);
    chk("R4 write at odd address", last_wa, 16'h3001);

    // R9 pipe inactive
    mem_win_en = 1;
    repeat (2) @(negedge clk);
    chk("R9 decoders back on", int'(mem_dec_en), 1);
    w = we_cnt;
    strobe(0, 1, 2'd1, 1, 16'h1234);
    load(8'h00, 8'h40);
    chk("R9 no write when inactive", we_cnt, w);
    chk("R9 pointer unchanged when inactive", int'(buf_ptr), 16'h3003);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    done = 1;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule